// File: doc/BRIEF.md
# Carry-Save Modulo Adder

This block adds two residues modulo a fixed modulus `MODULUS` without using any carry-propagate adder. Each operand arrives as two `N_BITS`-wide vectors, a sum part and a carry part. The operand's value is the total of the two parts, taken modulo the modulus. The result leaves the block in the same two-vector form. No carry ever ripples across the word, so the depth of every step is one full-adder cell, whatever the width.

Two carry-save levels of full adders merge the four input vectors into one pair. The bits that overflow past weight 2^n are then removed by three correction steps. Each step drops those bits and adds a fixed multiple of the gap 2^n − m, which is computed when the design is elaborated.

Each step has its own register stage. A new operation can enter on every cycle, and its result appears a fixed number of cycles later. Turning the result pair into a single binary number is left to whatever consumes it.

Top module: `csm_modadd`

## Requirements
- R1: For any four n-bit input vectors, (res_sum + res_cry) mod m equals (a_sum + a_cry + b_sum + b_cry) mod m.
- R2: While rst_n is low and directly after it, out_valid is 0 and res_sum and res_cry are 0.
- R3: An operation accepted with in_valid high shows out_valid high exactly five rising edges later, and in no other cycle.
- R4: Operations may be issued on consecutive cycles. Each result emerges one cycle after the previous one, in issue order.
- R5: A cycle with in_valid low gives out_valid low five cycles later, and its data has no effect on any valid result.
- R6: The extreme operands 0 and m − 1, given in plain form (carry part 0), produce the correct residue.
- R7: The last correction stage never leaves an overflow bit at weight 2^n. This holds even when all four input vectors are all ones.
- R8: With m = 2^n the correction constant is zero, and R1 still holds.
- R9: With m = 2050 and n = 12, adding 1272 and 450 (plain form) gives a pair whose total is congruent to 1722.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operands present this cycle |
| a_sum | input | N_BITS | Operand A, sum part |
| a_cry | input | N_BITS | Operand A, carry part |
| b_sum | input | N_BITS | Operand B, sum part |
| b_cry | input | N_BITS | Operand B, carry part |
| out_valid | output | 1 | Result pair valid |
| res_sum | output | N_BITS | Result, sum part |
| res_cry | output | N_BITS | Result, carry part |

## Verification
Every result is due five rising edges after its operands are driven. The bench drives on falling edges and keeps a five-deep queue of the operations it has issued, one entry per cycle including idle ones. It pops the oldest entry on each falling edge and compares it with the outputs at that moment, so data and the valid flag are judged in exactly the fifth cycle. A separate single-shot test walks the valid flag cycle by cycle after one isolated operation.

// File: rtl/csm_pkg.sv
package csm_pkg;

    // Distance from the modulus up to the next power of two.
    function automatic int gap_of(input int n, input int m);
        return (1 << n) - m;
    endfunction

endpackage

// File: rtl/csm_csa.sv
// One level of full adders: three vectors in, a sum vector and a carry
// vector (shifted up one place) out.
module csm_csa #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] sum,
    output logic [W:0]   cry
);
    assign cry[0] = 1'b0;

    for (genvar i = 0; i < W; i++) begin : g_cell
        assign sum[i]   = x[i] ^ y[i] ^ z[i];
        assign cry[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
endmodule

// File: rtl/csm_fix.sv
// Correction stage: if the carry vector holds a bit of weight 2^N, drop it
// and add the gap constant in carry-save form; otherwise pass the pair on.
module csm_fix #(
    parameter int N   = 4,
    parameter int GAP = 3
) (
    input  logic [N-1:0] s_in,
    input  logic [N:0]   c_in,
    output logic [N-1:0] s_out,
    output logic [N:0]   c_out
);
    localparam logic [N-1:0] ADD_V = GAP[N-1:0];

    logic [N-1:0] t_s;
    logic [N:0]   t_c;

    csm_csa #(.W(N)) u_csa (
        .x   (s_in),
        .y   (c_in[N-1:0]),
        .z   (ADD_V),
        .sum (t_s),
        .cry (t_c)
    );

    always_comb begin
        if (c_in[N]) begin
            s_out = t_s;
            c_out = t_c;
        end else begin
            s_out = s_in;
            c_out = {1'b0, c_in[N-1:0]};
        end
    end
endmodule

// File: rtl/csm_modadd.sv
module csm_modadd #(
    parameter int N_BITS  = 12,
    parameter int MODULUS = 2050
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N_BITS-1:0] a_sum,
    input  logic [N_BITS-1:0] a_cry,
    input  logic [N_BITS-1:0] b_sum,
    input  logic [N_BITS-1:0] b_cry,
    output logic              out_valid,
    output logic [N_BITS-1:0] res_sum,
    output logic [N_BITS-1:0] res_cry
);
    localparam int N     = N_BITS;
    localparam int NFIX  = 2;
    localparam int GAP   = csm_pkg::gap_of(N_BITS, MODULUS);
    localparam int GAP2  = 2 * GAP;
    localparam logic [N-1:0] GAP_V  = GAP[N-1:0];
    localparam logic [N-1:0] GAP2_V = GAP2[N-1:0];

    typedef struct packed {
        logic         v;
        logic [N-1:0] s;
        logic [N:0]   c;
        logic [N-1:0] bc;
    } lvl1_t;

    typedef struct packed {
        logic         v;
        logic [N:0]   s;
        logic [N+1:0] c;
    } lvl2_t;

    typedef struct packed {
        logic         v;
        logic [N-1:0] s;
        logic [N:0]   c;
    } fix_t;

    typedef struct packed {
        lvl1_t             p1;
        lvl2_t             p2;
        fix_t [NFIX:0]     px;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    // Step 1: A sum, A carry, B sum
    logic [N-1:0] l1_s;
    logic [N:0]   l1_c;
    csm_csa #(.W(N)) u_lvl1 (
        .x   (a_sum),
        .y   (a_cry),
        .z   (b_sum),
        .sum (l1_s),
        .cry (l1_c)
    );

    // Step 2: fold in B carry
    logic [N:0]   l2_s;
    logic [N+1:0] l2_c;
    csm_csa #(.W(N+1)) u_lvl2 (
        .x   ({1'b0, pipe_q.p1.s}),
        .y   (pipe_q.p1.c),
        .z   ({1'b0, pipe_q.p1.bc}),
        .sum (l2_s),
        .cry (l2_c)
    );

    // Step 3: count overflow bits, add 0, one or two gaps
    logic [1:0]   ovf_cnt;
    logic [N-1:0] k_add;
    logic [N-1:0] l3_s;
    logic [N:0]   l3_c;

    always_comb begin
        ovf_cnt = {1'b0, pipe_q.p2.s[N]} + {1'b0, pipe_q.p2.c[N]};
        case (ovf_cnt)
            2'd0:    k_add = '0;
            2'd1:    k_add = GAP_V;
            default: k_add = GAP2_V;
        endcase
    end

    csm_csa #(.W(N)) u_lvl3 (
        .x   (pipe_q.p2.s[N-1:0]),
        .y   (pipe_q.p2.c[N-1:0]),
        .z   (k_add),
        .sum (l3_s),
        .cry (l3_c)
    );

    // Steps 4 and 5: single-bit fix stages
    logic [N-1:0] fx_s [1:NFIX];
    logic [N:0]   fx_c [1:NFIX];

    for (genvar j = 1; j <= NFIX; j++) begin : g_fix
        csm_fix #(.N(N), .GAP(GAP)) u_fix (
            .s_in  (pipe_q.px[j-1].s),
            .c_in  (pipe_q.px[j-1].c),
            .s_out (fx_s[j]),
            .c_out (fx_c[j])
        );
    end

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.p1.v  = in_valid;
        pipe_d.p1.s  = l1_s;
        pipe_d.p1.c  = l1_c;
        pipe_d.p1.bc = b_cry;

        pipe_d.p2.v = pipe_q.p1.v;
        pipe_d.p2.s = l2_s;
        pipe_d.p2.c = l2_c;

        pipe_d.px[0].v = pipe_q.p2.v;
        if (ovf_cnt == 2'd0) begin
            pipe_d.px[0].s = pipe_q.p2.s[N-1:0];
            pipe_d.px[0].c = {1'b0, pipe_q.p2.c[N-1:0]};
        end else begin
            pipe_d.px[0].s = l3_s;
            pipe_d.px[0].c = l3_c;
        end

        for (int j = 1; j <= NFIX; j++) begin
            pipe_d.px[j].v = pipe_q.px[j-1].v;
            pipe_d.px[j].s = fx_s[j];
            pipe_d.px[j].c = fx_c[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.px[NFIX].v;
    assign res_sum   = pipe_q.px[NFIX].s;
    assign res_cry   = pipe_q.px[NFIX].c[N-1:0];

    // Cycles since reset, saturating, so the latency check never looks
    // back past the reset release.
    logic [2:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             warm_q <= '0;
        else if (warm_q != 3'd5) warm_q <= warm_q + 3'd1;
    end

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.px[NFIX].v |-> !pipe_q.px[NFIX].c[N]);

    p_lvl2_top_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.p2.v |-> !pipe_q.p2.c[N+1]);

    p_keep_residue_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pipe_q.px[0].v |->
            ((int'(pipe_q.px[0].s) + int'(pipe_q.px[0].c)) % MODULUS) ==
            $past((int'(pipe_q.p2.s) + int'(pipe_q.p2.c)) % MODULUS));

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 3'd5) |-> (out_valid == $past(in_valid, 5)));
endmodule

// File: tb/sim_csm_modadd.sv
module sim_csm_modadd;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       vin = 1'b0;
    logic [3:0] a0 = '0, a1 = '0, b0 = '0, b1 = '0;
    logic [11:0] w0 = '0, w1 = '0, w2 = '0, w3 = '0;

    logic       ov0, ov1, ov2;
    logic [3:0] rs0, rc0, rs1, rc1;
    logic [11:0] rs2, rc2;

    csm_modadd #(.N_BITS(4), .MODULUS(13)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(vin),
        .a_sum(a0), .a_cry(a1), .b_sum(b0), .b_cry(b1),
        .out_valid(ov0), .res_sum(rs0), .res_cry(rc0));

    csm_modadd #(.N_BITS(4), .MODULUS(16)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(vin),
        .a_sum(a0), .a_cry(a1), .b_sum(b0), .b_cry(b1),
        .out_valid(ov1), .res_sum(rs1), .res_cry(rc1));

    csm_modadd #(.N_BITS(12), .MODULUS(2050)) u2 (
        .clk(clk), .rst_n(rst_n), .in_valid(vin),
        .a_sum(w0), .a_cry(w1), .b_sum(w2), .b_cry(w3),
        .out_valid(ov2), .res_sum(rs2), .res_cry(rc2));

    int checks = 0;
    int fails  = 0;

    typedef struct {
        bit    v;
        int    a0, a1, b0, b1;
        int    w0, w1, w2, w3;
        string t0;
        string t2;
    } ent_t;

    ent_t q[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic judge(input ent_t x);
        string tv;
        tv = x.v ? "R3" : "R5";
        chk(tv, int'(ov0), int'(x.v));
        chk(tv, int'(ov1), int'(x.v));
        chk(tv, int'(ov2), int'(x.v));
        if (x.v) begin
            chk(x.t0, (int'(rs0) + int'(rc0)) % 13, (x.a0 + x.a1 + x.b0 + x.b1) % 13);
            chk("R8", (int'(rs1) + int'(rc1)) % 16, (x.a0 + x.a1 + x.b0 + x.b1) % 16);
            chk(x.t2, (int'(rs2) + int'(rc2)) % 2050, (x.w0 + x.w1 + x.w2 + x.w3) % 2050);
        end
    endtask

    task automatic tick(input ent_t e);
        @(negedge clk);
        if (q.size() == 5) judge(q.pop_front());
        vin = e.v;
        a0 = 4'(e.a0); a1 = 4'(e.a1); b0 = 4'(e.b0); b1 = 4'(e.b1);
        w0 = 12'(e.w0); w1 = 12'(e.w1); w2 = 12'(e.w2); w3 = 12'(e.w3);
        q.push_back(e);
    endtask

    function automatic ent_t mk(input bit v, input int p0, input int p1, input int p2,
                                input int p3, input int x0, input int x1, input int x2,
                                input int x3, input string ta, input string tb);
        ent_t e;
        e.v = v; e.a0 = p0; e.a1 = p1; e.b0 = p2; e.b1 = p3;
        e.w0 = x0; e.w1 = x1; e.w2 = x2; e.w3 = x3;
        e.t0 = ta; e.t2 = tb;
        return e;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: in reset, everything at zero
        chk("R2", int'(ov0), 0);
        chk("R2", int'(rs0) + int'(rc0), 0);
        chk("R2", int'(ov2), 0);
        chk("R2", int'(rs2) + int'(rc2), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R2", int'(ov0), 0);

        // R3: one isolated operation, watch valid cycle by cycle
        vin = 1'b1; a0 = 4'd12; b0 = 4'd12; w0 = 12'd2049; w2 = 12'd2049;
        @(negedge clk);
        vin = 1'b0;
        for (int k = 1; k <= 7; k++) begin
            chk("R3", int'(ov0), int'(k == 5));
            chk("R3", int'(ov2), int'(k == 5));
            if (k == 5) begin
                chk("R6", (int'(rs0) + int'(rc0)) % 13, 11);
                chk("R6", (int'(rs2) + int'(rc2)) % 2050, 2048);
            end
            if (k < 7) @(negedge clk);
        end
        a0 = '0; b0 = '0; w0 = '0; w2 = '0;

        // R1, R4, R5, R8: every 4-bit input combination, back to back
        for (int i = 0; i < 65536; i++) begin
            tick(mk(1'b1, i & 15, (i >> 4) & 15, (i >> 8) & 15, (i >> 12) & 15,
                    int'($urandom_range(4095)), int'($urandom_range(4095)),
                    int'($urandom_range(4095)), int'($urandom_range(4095)), "R1", "R4"));
            if (i % 1000 == 999)
                tick(mk(1'b0, 15, 15, 15, 15, 4095, 4095, 4095, 4095, "R5", "R5"));
        end

        // R6, R7, R9 on the wide configuration
        tick(mk(1'b1, 12, 0, 12, 0, 2049, 0, 2049, 0, "R6", "R6"));
        tick(mk(1'b1, 0, 0, 0, 0, 0, 0, 0, 0, "R6", "R6"));
        tick(mk(1'b1, 0, 0, 12, 0, 0, 0, 2049, 0, "R6", "R6"));
        tick(mk(1'b1, 1, 2, 3, 4, 1272, 0, 450, 0, "R1", "R9"));
        tick(mk(1'b1, 15, 15, 15, 15, 4095, 4095, 4095, 4095, "R7", "R7"));
        tick(mk(1'b1, 15, 15, 15, 14, 4095, 4095, 4095, 2049, "R7", "R7"));
        for (int d = 0; d < 6; d++)
            tick(mk(1'b0, 0, 0, 0, 0, 0, 0, 0, 0, "R5", "R5"));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule